// File: doc/BRIEF.md
# Two-Master Register Port Arbiter

This block lets two bus masters share a single byte-wide register and data port of a decoder core. One master is the host processor bus, which carries register reads and writes. The other is a DMA engine, which moves data through the core toward memory. Each master has its own request, grant, write enable, address, write data, read data and acknowledge. The arbiter grants one master at a time. It forwards that master's word address, low data byte and write enable to the core. It sends the core's acknowledge and read byte back to the granted master only.

Arbitration uses fixed priority, and the processor always wins a tie. A grant stays in place until the core acknowledges, so an access that has started is never cut short. A master must hold its request, address and data stable until it sees its acknowledge, and must then drop its request for at least one cycle. The core port carries only the low byte of the 32-bit data word. Upper write bits are discarded, and upper read bits return zero.

The controller has three states. IDLE holds no grant. CPU_OWN grants the processor. DMA_OWN grants the DMA engine. The transitions are:
- IDLE→CPU_OWN when the processor requests.
- IDLE→DMA_OWN when only the DMA engine requests.
- CPU_OWN→IDLE and DMA_OWN→IDLE on a core acknowledge.
- Each state stays where it is otherwise.

Top module: `regbus_arbiter`

## Requirements
- R1: After reset the controller is in IDLE: both grants are 0, core_sel is 0, and both acknowledges are 0.
- R2: When the processor requests in IDLE, the processor grant is 1 in the next cycle, whether or not the DMA engine also requests.
- R3: A grant stays unchanged until the core raises core_ack. A processor request that arrives while the DMA engine holds the grant does not take the grant away.
- R4: A DMA request in IDLE with no processor request is granted in the next cycle. A DMA request that lost a tie stays pending and is granted after the next IDLE cycle in which the processor does not request.
- R5: While a master is granted, core_addr equals that master's address bits [31:2], core_wdata equals its write data bits [7:0], and core_we equals its write enable.
- R6: The granted master's read data is {24'h0, core_rdata} while the core acknowledges. The other master's read data is zero.
- R7: core_ack is passed only to the granted master. The other master sees no acknowledge, and the two acknowledges are never high together.
- R8: After an acknowledge the controller spends exactly one cycle in IDLE with both grants 0 before it grants again.
- R9: In IDLE, core_sel, core_we, core_addr and core_wdata are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor write enable (1 = write) |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data; only bits [7:0] are used |
| cpu_gnt | output | 1 | Processor owns the core port |
| cpu_ack | output | 1 | Processor access complete |
| cpu_rdata | output | 32 | Processor read data; upper 24 bits are zero |
| dma_req | input | 1 | DMA access request |
| dma_we | input | 1 | DMA write enable (1 = write) |
| dma_addr | input | 32 | DMA byte address |
| dma_wdata | input | 32 | DMA write data; only bits [7:0] are used |
| dma_gnt | output | 1 | DMA engine owns the core port |
| dma_ack | output | 1 | DMA access complete |
| dma_rdata | output | 32 | DMA read data; upper 24 bits are zero |
| core_sel | output | 1 | Core access strobe |
| core_we | output | 1 | Core write enable |
| core_addr | output | 30 | Core word address |
| core_wdata | output | 8 | Core write byte |
| core_rdata | input | 8 | Core read byte |
| core_ack | input | 1 | Core access complete |

## Verification
The bench builds the block with its default widths: 32-bit master buses, an 8-bit core lane and a 30-bit word address. The sweep covers every non-empty request pattern (processor only, DMA only, both at once), both access directions, and core acknowledge latencies of zero to three cycles. Under these values a single bench can reach the tie break, the deferred DMA grant, and a processor request that arrives during a long DMA access. Master write data carries non-zero upper bits, so the bench can confirm that those bits never reach the core.

// File: rtl/regarb_pkg.sv
package regarb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_CPU_OWN = 2'd1,
        ARB_DMA_OWN = 2'd2
    } arb_state_e;

    // Master index: lower index means higher priority
    localparam int unsigned MST_CPU = 0;
    localparam int unsigned MST_DMA = 1;
    localparam int unsigned NUM_MST = 2;

endpackage

// File: rtl/regarb_fsm.sv
module regarb_fsm
    import regarb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MST-1:0] req,
    input  logic               core_ack,
    output logic [NUM_MST-1:0] gnt
);

    arb_state_e state_q;
    arb_state_e state_d;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (req[MST_CPU])      state_d = ARB_CPU_OWN;
                else if (req[MST_DMA]) state_d = ARB_DMA_OWN;
            end
            ARB_CPU_OWN: if (core_ack) state_d = ARB_IDLE;
            ARB_DMA_OWN: if (core_ack) state_d = ARB_IDLE;
            default:     state_d = ARB_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // Grant outputs
    always_comb begin
        gnt = '0;
        unique case (state_q)
            ARB_IDLE:    gnt = '0;
            ARB_CPU_OWN: gnt[MST_CPU] = 1'b1;
            ARB_DMA_OWN: gnt[MST_DMA] = 1'b1;
            default:     gnt = '0;
        endcase
    end

    assert_cpu_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0 && req[MST_CPU]) |=> gnt[MST_CPU]);

    assert_hold_cpu_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt[MST_CPU] && !core_ack) |=> gnt[MST_CPU]);

    assert_hold_dma_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt[MST_DMA] && !core_ack) |=> gnt[MST_DMA]);

    assert_dma_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0 && !req[MST_CPU] && req[MST_DMA]) |=> gnt[MST_DMA]);

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt != '0) && core_ack) |=> (gnt == '0));

endmodule

// File: rtl/regarb_fwd.sv
module regarb_fwd
    import regarb_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned WORD_SH = $clog2(DATA_W / 8),
    localparam int unsigned CORE_AW = ADDR_W - WORD_SH
) (
    input  logic [NUM_MST-1:0]             gnt,
    input  logic [NUM_MST-1:0]             m_we,
    input  logic [NUM_MST-1:0][ADDR_W-1:0] m_addr,
    input  logic [NUM_MST-1:0][DATA_W-1:0] m_wdata,
    output logic                           core_sel,
    output logic                           core_we,
    output logic [CORE_AW-1:0]             core_addr,
    output logic [LANE_W-1:0]              core_wdata
);

    // Grants are one-hot or zero, so an OR of gated masters forms the mux
    always_comb begin
        core_we    = 1'b0;
        core_addr  = '0;
        core_wdata = '0;
        for (int unsigned m = 0; m < NUM_MST; m++) begin
            core_we    = core_we    | (gnt[m] & m_we[m]);
            core_addr  = core_addr  | (m_addr[m][ADDR_W-1:WORD_SH] & {CORE_AW{gnt[m]}});
            core_wdata = core_wdata | (m_wdata[m][LANE_W-1:0]      & {LANE_W{gnt[m]}});
        end
    end

    assign core_sel = |gnt;

    // Byte offset and reserved data bits are deliberately dropped
    logic unused_bits;
    always_comb begin
        unused_bits = 1'b0;
        for (int unsigned m = 0; m < NUM_MST; m++) begin
            unused_bits = unused_bits ^ (^m_addr[m][WORD_SH-1:0]) ^ (^m_wdata[m][DATA_W-1:LANE_W]);
        end
    end

endmodule

// File: rtl/regarb_ret.sv
module regarb_ret #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 8
) (
    input  logic              gnt,
    input  logic              core_ack,
    input  logic [LANE_W-1:0] core_rdata,
    output logic              m_ack,
    output logic [DATA_W-1:0] m_rdata
);

    always_comb begin
        m_ack   = gnt & core_ack;
        m_rdata = '0;
        if (m_ack) m_rdata[LANE_W-1:0] = core_rdata;
    end

endmodule

// File: rtl/regbus_arbiter.sv
module regbus_arbiter
    import regarb_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned CORE_AW = ADDR_W - $clog2(DATA_W / 8)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic               cpu_gnt,
    output logic               cpu_ack,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic               dma_req,
    input  logic               dma_we,
    input  logic [ADDR_W-1:0]  dma_addr,
    input  logic [DATA_W-1:0]  dma_wdata,
    output logic               dma_gnt,
    output logic               dma_ack,
    output logic [DATA_W-1:0]  dma_rdata,
    output logic               core_sel,
    output logic               core_we,
    output logic [CORE_AW-1:0] core_addr,
    output logic [LANE_W-1:0]  core_wdata,
    input  logic [LANE_W-1:0]  core_rdata,
    input  logic               core_ack
);

    logic [NUM_MST-1:0]             req;
    logic [NUM_MST-1:0]             gnt;
    logic [NUM_MST-1:0]             m_we;
    logic [NUM_MST-1:0][ADDR_W-1:0] m_addr;
    logic [NUM_MST-1:0][DATA_W-1:0] m_wdata;
    logic [NUM_MST-1:0]             m_ack;
    logic [NUM_MST-1:0][DATA_W-1:0] m_rdata;

    always_comb begin
        req[MST_CPU]     = cpu_req;
        req[MST_DMA]     = dma_req;
        m_we[MST_CPU]    = cpu_we;
        m_we[MST_DMA]    = dma_we;
        m_addr[MST_CPU]  = cpu_addr;
        m_addr[MST_DMA]  = dma_addr;
        m_wdata[MST_CPU] = cpu_wdata;
        m_wdata[MST_DMA] = dma_wdata;
    end

    regarb_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .core_ack (core_ack),
        .gnt      (gnt)
    );

    regarb_fwd #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_fwd (
        .gnt        (gnt),
        .m_we       (m_we),
        .m_addr     (m_addr),
        .m_wdata    (m_wdata),
        .core_sel   (core_sel),
        .core_we    (core_we),
        .core_addr  (core_addr),
        .core_wdata (core_wdata)
    );

    for (genvar m = 0; m < NUM_MST; m++) begin : g_ret
        regarb_ret #(
            .DATA_W (DATA_W),
            .LANE_W (LANE_W)
        ) u_ret (
            .gnt        (gnt[m]),
            .core_ack   (core_ack),
            .core_rdata (core_rdata),
            .m_ack      (m_ack[m]),
            .m_rdata    (m_rdata[m])
        );
    end

    assign cpu_gnt   = gnt[MST_CPU];
    assign dma_gnt   = gnt[MST_DMA];
    assign cpu_ack   = m_ack[MST_CPU];
    assign dma_ack   = m_ack[MST_DMA];
    assign cpu_rdata = m_rdata[MST_CPU];
    assign dma_rdata = m_rdata[MST_DMA];

    assert_ack_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ack && dma_ack));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_gnt || dma_gnt) |-> (core_addr == '0 && core_wdata == '0 && !core_we));

endmodule

// File: tb/regbus_arbiter_tb_top.sv
`timescale 1ns/1ps
module regbus_arbiter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 0, cpu_we = 0, dma_req = 0, dma_we = 0;
    logic [31:0] cpu_addr = 0, cpu_wdata = 0, dma_addr = 0, dma_wdata = 0;
    logic        cpu_gnt, cpu_ack, dma_gnt, dma_ack;
    logic [31:0] cpu_rdata, dma_rdata;
    logic        core_sel, core_we;
    logic [29:0] core_addr;
    logic [7:0]  core_wdata;
    logic [7:0]  core_rdata = 0;
    logic        core_ack = 0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    regbus_arbiter dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_gnt(cpu_gnt), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .dma_gnt(dma_gnt), .dma_ack(dma_ack), .dma_rdata(dma_rdata),
        .core_sel(core_sel), .core_we(core_we), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_rdata(core_rdata), .core_ack(core_ack)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // who: 1 = processor, 2 = DMA
    task automatic chk_owner(string tag, int who, logic [31:0] addr, logic [31:0] wd, logic we);
        chk({tag, " cpu_gnt"}, 32'(cpu_gnt), 32'(who == 1));
        chk({tag, " dma_gnt"}, 32'(dma_gnt), 32'(who == 2));
        chk({tag, " core_sel"}, 32'(core_sel), 32'(who != 0));
        chk("R5 core_addr", 32'(core_addr), (who != 0) ? (addr >> 2) : 32'h0);
        chk("R5 core_wdata", 32'(core_wdata), (who != 0) ? (wd & 32'hFF) : 32'h0);
        chk("R5 core_we", 32'(core_we), (who != 0) ? 32'(we) : 32'h0);
    endtask

    // Acknowledge the current owner with byte b, check return path, then IDLE
    task automatic finish_access(int who, logic [7:0] b);
        core_ack = 1'b1;
        core_rdata = b;
        #1;
        chk("R7 cpu_ack", 32'(cpu_ack), 32'(who == 1));
        chk("R7 dma_ack", 32'(dma_ack), 32'(who == 2));
        chk("R6 cpu_rdata", cpu_rdata, (who == 1) ? {24'h0, b} : 32'h0);
        chk("R6 dma_rdata", dma_rdata, (who == 2) ? {24'h0, b} : 32'h0);
        @(negedge clk);
        core_ack = 1'b0;
        if (who == 1) cpu_req = 1'b0; else dma_req = 1'b0;
        #1;
        chk_owner("R8 idle gap", 0, 0, 0, 0);
        chk("R9 acks low", 32'({cpu_ack, dma_ack}), 32'h0);
    endtask

    task automatic run_case(logic cr, logic dr, int lat, logic we, int k);
        int win;
        logic [7:0] b;
        @(negedge clk);
        cpu_addr  = 32'hBE42_0000 + 32'(k * 4) + 32'(k % 4);
        dma_addr  = 32'h0040_1000 + 32'(k * 12) + 32'((k + 1) % 4);
        cpu_wdata = 32'h5A5A_5A00 | 32'(k * 7);
        dma_wdata = 32'hC3C3_C300 | 32'(k * 11 + 3);
        cpu_we = we;
        dma_we = ~we;
        cpu_req = cr;
        dma_req = dr;
        win = cr ? 1 : 2;
        b = 8'(k * 37 + lat);
        @(negedge clk);
        #1;
        if (win == 1) chk_owner("R2 tie/cpu win", 1, cpu_addr, cpu_wdata, cpu_we);
        else          chk_owner("R4 dma alone", 2, dma_addr, dma_wdata, dma_we);
        // Processor request arriving mid-DMA must not preempt
        if (win == 2) cpu_req = 1'b1;
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            #1;
            if (win == 1) chk_owner("R3 hold cpu", 1, cpu_addr, cpu_wdata, cpu_we);
            else          chk_owner("R3 hold dma", 2, dma_addr, dma_wdata, dma_we);
            chk("R7 no early ack", 32'({cpu_ack, dma_ack}), 32'h0);
        end
        finish_access(win, b);
        // The other master, if still requesting, is granted after the gap
        if (cpu_req || dma_req) begin
            @(negedge clk);
            #1;
            if (cpu_req) begin
                chk_owner("R2 cpu after dma", 1, cpu_addr, cpu_wdata, cpu_we);
                finish_access(1, ~b);
            end else begin
                chk_owner("R4 deferred dma", 2, dma_addr, dma_wdata, dma_we);
                finish_access(2, ~b);
            end
        end
    endtask

    initial begin
        int k = 0;
        #1;
        chk_owner("R1 reset", 0, 0, 0, 0);
        chk("R1 acks", 32'({cpu_ack, dma_ack}), 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk_owner("R1 after reset", 0, 0, 0, 0);
        for (int p = 1; p < 4; p++) begin
            for (int lat = 0; lat < 4; lat++) begin
                for (int w = 0; w < 2; w++) begin
                    run_case(p[0], p[1], lat, w[0], k);
                    k++;
                end
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule